// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences trap entry and trap return for a small 32-bit RISC core whose branches have delay slots. When the pipeline reports an exception it supplies a cause index, the PC of the offending instruction, a flag telling whether that instruction sits in a delay slot, and a fault address from the translation logic. In one clock the block saves the resume PC, the pre-trap status word and, for some causes, the error address. It then rewrites the status word for supervisor operation and redirects fetch to a vector derived from the cause.

A return strobe reverses the entry: fetch resumes at the saved PC and the saved status word comes back into the live one. The register file, decode, address translation and memory are outside the block. It only consumes cause codes and addresses and drives the redirect PC and the special registers.

Status word bits used here: bit 0 supervisor mode, bit 1 tick-exception enable, bit 2 interrupt enable, bit 13 delay-slot exception flag, bit 15 fixed one. Cause indices: 3 data page fault, 4 instruction page fault, 7 illegal instruction, 9 data TLB miss, 10 instruction TLB miss, 12 system call. Fifteen causes (0 to 14) are defined.

Top module: `exc_seq`

## Requirements
- R1: While reset is held, pc_o is 0x100, npc_o is 0x104, sr_o is 0x8001 (fixed-one and supervisor bits only), esr_o, epcr_o and eear_o are 0, and redirect_o is low.
- R2: An accepted exception (exc_valid_i with a cause from 1 to 14) sets pc_o to the cause shifted left by 8 and npc_o to that value plus 4 at the next edge, with redirect_o high for that cycle.
- R3: When the excepting instruction is in a delay slot, epcr_o becomes exc_pc_i minus 4 and sr_o bit 13 is set.
- R4: When the excepting instruction is not in a delay slot, epcr_o becomes exc_pc_i and sr_o bit 13 is cleared.
- R5: For cause 12 (system call) the saved epcr_o is 4 more than the value R3 or R4 would give.
- R6: For cause 7 (illegal instruction) eear_o is loaded with exc_pc_i.
- R7: For causes 3, 4, 9 and 10 eear_o is loaded with exc_fault_addr_i; every other cause leaves eear_o unchanged.
- R8: On entry esr_o takes the pre-entry status word, and sr_o becomes that word with bit 0 set, bits 1 and 2 cleared and bits other than 13 unchanged.
- R9: A request with cause 0 or a cause of 15 or more is ignored: no register changes and redirect_o stays low.
- R10: rfe_i alone sets pc_o and npc_o to epcr_o, copies esr_o into sr_o, and raises redirect_o for one cycle.
- R11: When an accepted exception and rfe_i arrive together, the exception wins and takes the restored status word (the old esr_o) as its context for R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception request |
| exc_cause_i | input | 5 | Exception cause index |
| exc_pc_i | input | 32 | PC of the excepting instruction |
| exc_in_dslot_i | input | 1 | Excepting instruction is in a delay slot |
| exc_fault_addr_i | input | 32 | Faulting address from translation |
| rfe_i | input | 1 | Return-from-exception strobe |
| redirect_o | output | 1 | Fetch must restart at pc_o |
| pc_o | output | 32 | Program counter |
| npc_o | output | 32 | Next program counter |
| sr_o | output | 32 | Live status word |
| esr_o | output | 32 | Saved status word |
| epcr_o | output | 32 | Saved exception PC |
| eear_o | output | 32 | Error effective address |

## Verification
Exception entry and return can land in the same cycle, which is the case where a wrong priority or a stale context would go unnoticed. The bench first builds a state where saved and live status words differ in the delay-slot bit, then asserts a system-call request together with the return strobe. It judges the result by the vector in pc_o, by the system-call-adjusted epcr_o, and by esr_o holding the old saved word rather than the live one.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned SR_SUPV      = 0;
  localparam int unsigned SR_TICK_EN   = 1;
  localparam int unsigned SR_IRQ_EN    = 2;
  localparam int unsigned SR_DSLOT_EXC = 13;
  localparam int unsigned SR_FIXED_ONE = 15;

  localparam int unsigned CAUSE_DPF     = 3;
  localparam int unsigned CAUSE_IPF     = 4;
  localparam int unsigned CAUSE_ILLEGAL = 7;
  localparam int unsigned CAUSE_DTLB    = 9;
  localparam int unsigned CAUSE_ITLB    = 10;
  localparam int unsigned CAUSE_SYSCALL = 12;

  typedef struct packed {
    logic ok;
    logic syscall;
    logic illegal;
    logic mmu;
  } cause_class_t;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 5,
  parameter int unsigned NUM_CAUSES = 15,
  parameter int unsigned VEC_SHIFT  = 8
) (
  input  logic [CAUSE_W-1:0]          cause_i,
  output exc_seq_pkg::cause_class_t   class_o,
  output logic [XLEN-1:0]             vector_o
);
  import exc_seq_pkg::*;

  logic [NUM_CAUSES-1:0] hit;
  logic [NUM_CAUSES-1:0] mmu_mask;

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_hit
    assign hit[i] = (cause_i == CAUSE_W'(i));
    assign mmu_mask[i] = (i == CAUSE_DPF) || (i == CAUSE_IPF) ||
                         (i == CAUSE_DTLB) || (i == CAUSE_ITLB);
  end

  always_comb begin
    class_o.ok      = |hit[NUM_CAUSES-1:1];
    class_o.syscall = hit[CAUSE_SYSCALL];
    class_o.illegal = hit[CAUSE_ILLEGAL];
    class_o.mmu     = |(hit & mmu_mask);
  end

  assign vector_o = XLEN'(cause_i) << VEC_SHIFT;
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] exc_pc_i,
  input  logic            in_dslot_i,
  input  logic            syscall_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] back;
  logic [XLEN-1:0] fwd;

  // branch address for delay slot, resume-after for syscall
  assign back  = in_dslot_i ? STEP : '0;
  assign fwd   = syscall_i  ? STEP : '0;
  assign epc_o = exc_pc_i - back + fwd;
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] ctx_sr_i,
  input  logic            in_dslot_i,
  output logic [XLEN-1:0] sr_o
);
  import exc_seq_pkg::*;

  always_comb begin
    sr_o               = ctx_sr_i;
    sr_o[SR_SUPV]      = 1'b1;
    sr_o[SR_TICK_EN]   = 1'b0;
    sr_o[SR_IRQ_EN]    = 1'b0;
    sr_o[SR_DSLOT_EXC] = in_dslot_i;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CAUSE_W    = 5,
  parameter int unsigned NUM_CAUSES = 15,
  parameter int unsigned VEC_SHIFT  = 8,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h0000_0100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic               exc_in_dslot_i,
  input  logic [XLEN-1:0]    exc_fault_addr_i,
  input  logic               rfe_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    npc_o,
  output logic [XLEN-1:0]    sr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    epcr_o,
  output logic [XLEN-1:0]    eear_o
);
  import exc_seq_pkg::*;

  localparam logic [XLEN-1:0] PC_RST  = XLEN'(RESET_PC);
  localparam logic [XLEN-1:0] NPC_RST = PC_RST + XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] SR_RST  = (XLEN'(1) << SR_FIXED_ONE) | (XLEN'(1) << SR_SUPV);

  cause_class_t    cls;
  logic [XLEN-1:0] vector;
  logic [XLEN-1:0] epc_next;
  logic [XLEN-1:0] ctx_sr;
  logic [XLEN-1:0] sr_entry;
  logic            take_exc;
  logic            take_rfe;

  exc_cause_decode #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES), .VEC_SHIFT(VEC_SHIFT)
  ) u_decode (
    .cause_i  (exc_cause_i),
    .class_o  (cls),
    .vector_o (vector)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .exc_pc_i   (exc_pc_i),
    .in_dslot_i (exc_in_dslot_i),
    .syscall_i  (cls.syscall),
    .epc_o      (epc_next)
  );

  // a same-cycle return hands its restored word to the entry
  assign ctx_sr = rfe_i ? esr_o : sr_o;

  exc_sr_update #(.XLEN(XLEN)) u_sr (
    .ctx_sr_i   (ctx_sr),
    .in_dslot_i (exc_in_dslot_i),
    .sr_o       (sr_entry)
  );

  assign take_exc = exc_valid_i && cls.ok;
  assign take_rfe = rfe_i && !take_exc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      pc_o       <= PC_RST;
      npc_o      <= NPC_RST;
      sr_o       <= SR_RST;
      esr_o      <= '0;
      epcr_o     <= '0;
      eear_o     <= '0;
    end else if (take_exc) begin
      redirect_o <= 1'b1;
      pc_o       <= vector;
      npc_o      <= vector + XLEN'(INSN_BYTES);
      esr_o      <= ctx_sr;
      sr_o       <= sr_entry;
      epcr_o     <= epc_next;
      if (cls.illegal)  eear_o <= exc_pc_i;
      else if (cls.mmu) eear_o <= exc_fault_addr_i;
    end else if (take_rfe) begin
      redirect_o <= 1'b1;
      pc_o       <= epcr_o;
      npc_o      <= epcr_o;
      sr_o       <= esr_o;
    end else begin
      redirect_o <= 1'b0;
    end
  end

  assert_vector_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok) |=> (redirect_o && pc_o == (XLEN'($past(exc_cause_i)) << VEC_SHIFT)));

  assert_dslot_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok && exc_in_dslot_i) |=> sr_o[SR_DSLOT_EXC]);

  assert_dslot_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok && !exc_in_dslot_i) |=> !sr_o[SR_DSLOT_EXC]);

  assert_illegal_eear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok && cls.illegal) |=> eear_o == $past(exc_pc_i));

  assert_class_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cls.syscall, cls.illegal, cls.mmu}));

  assert_esr_save_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok && !rfe_i) |=> esr_o == $past(sr_o));

  assert_supv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok) |=> (sr_o[SR_SUPV] && !sr_o[SR_TICK_EN] && !sr_o[SR_IRQ_EN]));

  assert_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && !cls.ok && !rfe_i) |=> ($stable(pc_o) && $stable(sr_o) && $stable(eear_o) && !redirect_o));

  assert_rfe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !(exc_valid_i && cls.ok)) |=> (pc_o == $past(epcr_o) && sr_o == $past(esr_o) && redirect_o));

  assert_collide_ctx_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && cls.ok && rfe_i) |=> esr_o == $past(esr_o));
endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_cause = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_dslot = 1'b0;
  logic [31:0] exc_faddr = '0;
  logic        rfe = 1'b0;
  logic        redirect;
  logic [31:0] pc, npc, sr, esr, epcr, eear;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        m_redir;
  logic [31:0] m_pc, m_npc, m_sr, m_esr, m_epcr, m_eear;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_seq u_exc_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_valid_i(exc_valid), .exc_cause_i(exc_cause), .exc_pc_i(exc_pc),
    .exc_in_dslot_i(exc_dslot), .exc_fault_addr_i(exc_faddr), .rfe_i(rfe),
    .redirect_o(redirect), .pc_o(pc), .npc_o(npc), .sr_o(sr),
    .esr_o(esr), .epcr_o(epcr), .eear_o(eear)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "redirect", 32'(redirect), 32'(m_redir));
    chk(tag, "pc", pc, m_pc);
    chk(tag, "npc", npc, m_npc);
    chk(tag, "sr", sr, m_sr);
    chk(tag, "esr", esr, m_esr);
    chk(tag, "epcr", epcr, m_epcr);
    chk(tag, "eear", eear, m_eear);
  endtask

  // drive one cycle at negedge, advance the reference, check at the next negedge
  task automatic step(input logic v, input logic [4:0] c, input logic [31:0] p,
                      input logic d, input logic [31:0] fa, input logic r, input string tag);
    logic        ok;
    logic [31:0] ctx;
    exc_valid = v; exc_cause = c; exc_pc = p; exc_dslot = d; exc_faddr = fa; rfe = r;
    @(posedge clk);
    @(negedge clk);
    ok  = v && (c != 0) && (c < 15);
    ctx = r ? m_esr : m_sr;
    if (ok) begin
      m_redir = 1'b1;
      m_esr   = ctx;
      m_sr    = (ctx | 32'h1) & ~32'h6;
      m_sr[13] = d;
      m_epcr  = p - (d ? 32'd4 : 32'd0) + ((c == 12) ? 32'd4 : 32'd0);
      if (c == 7) m_eear = p;
      else if (c == 3 || c == 4 || c == 9 || c == 10) m_eear = fa;
      m_pc    = 32'(c) << 8;
      m_npc   = m_pc + 32'd4;
    end else if (r) begin
      m_redir = 1'b1;
      m_pc = m_epcr; m_npc = m_epcr; m_sr = m_esr;
    end else begin
      m_redir = 1'b0;
    end
    exc_valid = 1'b0; rfe = 1'b0; exc_dslot = 1'b0;
    chk_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic t_reset_r1;
    m_redir = 1'b0; m_pc = 32'h100; m_npc = 32'h104; m_sr = 32'h8001;
    m_esr = '0; m_epcr = '0; m_eear = '0;
    #(CLK_PERIOD * 2.5);
    chk_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
  endtask

  task automatic t_plain_r2;
    step(1'b1, 5'd5, 32'h2000, 1'b0, 32'h0, 1'b0, "R2");
    chk("R2", "vector", pc, 32'h500);
    chk("R4", "epcr plain", epcr, 32'h2000);
    idle("R2");
    chk("R2", "redirect drops", 32'(redirect), 32'd0);
  endtask

  task automatic t_dslot_r3_r4;
    step(1'b1, 5'd8, 32'h3004, 1'b1, 32'h0, 1'b0, "R3");
    chk("R3", "branch pc", epcr, 32'h3000);
    chk("R3", "dslot bit", 32'(sr[13]), 32'd1);
    step(1'b1, 5'd6, 32'h4000, 1'b0, 32'h0, 1'b0, "R4");
    chk("R4", "dslot cleared", 32'(sr[13]), 32'd0);
    chk("R8", "esr holds prior sr", esr, 32'hA001);
  endtask

  task automatic t_syscall_r5;
    step(1'b1, 5'd12, 32'h5000, 1'b0, 32'h0, 1'b0, "R5");
    chk("R5", "syscall epcr", epcr, 32'h5004);
    step(1'b1, 5'd12, 32'h5008, 1'b1, 32'h0, 1'b0, "R5");
    chk("R5", "syscall dslot epcr", epcr, 32'h5008);
    chk("R5", "vector", pc, 32'hC00);
  endtask

  task automatic t_illegal_r6;
    step(1'b1, 5'd7, 32'h6000, 1'b0, 32'hDEAD_0000, 1'b0, "R6");
    chk("R6", "eear", eear, 32'h6000);
  endtask

  task automatic t_mmu_r7;
    step(1'b1, 5'd3, 32'h7100, 1'b0, 32'h1234_5678, 1'b0, "R7");
    chk("R7", "dpf eear", eear, 32'h1234_5678);
    step(1'b1, 5'd10, 32'h7200, 1'b0, 32'h0000_9ABC, 1'b0, "R7");
    chk("R7", "itlb eear", eear, 32'h0000_9ABC);
    step(1'b1, 5'd11, 32'h7300, 1'b0, 32'h1111_1111, 1'b0, "R7");
    chk("R7", "eear kept", eear, 32'h0000_9ABC);
  endtask

  task automatic t_invalid_r9;
    step(1'b1, 5'd0, 32'h8800, 1'b1, 32'h2222_2222, 1'b0, "R9");
    step(1'b1, 5'd15, 32'h8900, 1'b0, 32'h3333_3333, 1'b0, "R9");
    step(1'b1, 5'd31, 32'h8A00, 1'b1, 32'h4444_4444, 1'b0, "R9");
    chk("R9", "no redirect", 32'(redirect), 32'd0);
    chk("R9", "eear kept", eear, 32'h0000_9ABC);
  endtask

  task automatic t_rfe_r10;
    step(1'b1, 5'd8, 32'h9004, 1'b1, 32'h0, 1'b0, "R10");
    step(1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 1'b1, "R10");
    chk("R10", "pc", pc, 32'h9000);
    chk("R10", "npc", npc, 32'h9000);
    chk("R10", "sr from esr", sr, 32'h8001);
  endtask

  task automatic t_collide_r11;
    step(1'b1, 5'd8, 32'hA004, 1'b1, 32'h0, 1'b0, "R11");
    step(1'b1, 5'd5, 32'hB000, 1'b0, 32'h0, 1'b0, "R11");
    chk("R11", "setup esr", esr, 32'hA001);
    step(1'b1, 5'd12, 32'hC000, 1'b0, 32'h0, 1'b1, "R11");
    chk("R11", "vector wins", pc, 32'hC00);
    chk("R11", "epcr", epcr, 32'hC004);
    chk("R11", "esr from restored", esr, 32'hA001);
  endtask

  initial begin
    t_reset_r1();
    t_plain_r2();
    t_dslot_r3_r4();
    t_syscall_r5();
    t_illegal_r6();
    t_mmu_r7();
    t_invalid_r9();
    t_rfe_r10();
    t_collide_r11();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule